// File: doc/BRIEF.md
# Two-Wire Serial Slave with Motor Control and Fault Registers

This block is the host-facing side of a brushed motor driver. It sits on a two-wire serial bus (SCL and SDA) as a slave and holds two registers. A control register sets the motor drive voltage code and the two bridge control bits. A fault register reads back fault status bits supplied from outside and takes a write-one clear command. The block only ever pulls SDA low and leaves the line otherwise released. It does not stretch the clock, take part in arbitration or answer the general call address.

A transfer begins with a START. The first byte carries a 7-bit address and a direction bit. After a write address, the first data byte selects a register and each later byte is written to that register. After a read address, the block returns the register chosen by the most recent selection, one byte per clock group, for as long as the master acknowledges. The 7-bit address is a fixed base plus an offset set by two three-level pins. These pins are sampled once, just after reset.

Both bus lines pass through synchronisers, and all bus events are detected on the system clock. The system clock must therefore run at many times the bus bit rate.

Top module: `mci2cSlave`

## Requirements
- R1: A transfer starts only on a START (SDA falls while SCL is high) and ends on a STOP (SDA rises while SCL is high). Clock pulses that come before any START get no acknowledge and change no register.
- R2: Each address pin is coded 2'b00 = tied low (weight 0), 2'b01 = tied high (weight 2), 2'b10 or 2'b11 = open (weight 1). The 7-bit device address is 0x60 + 3*weight(addrSel1) + weight(addrSel0). The address byte is sent MSB first, and bit 0 is the direction bit (1 = read).
- R3: The address pins are captured on the first clock after reset is released. Later changes on the pins do not change the address the block answers to.
- R4: When the address matches, the block pulls SDA low through the ninth SCL high. When the address does not match, or is the general call address 0x00, the block gives no acknowledge and ignores the bus until the next START.
- R5: After a write address, the first data byte selects the register and each later byte in the same transfer is written to that register. Every data byte is acknowledged, and the selection does not advance between bytes.
- R6: A written byte takes effect only at the SCL falling edge that ends its acknowledge clock. A STOP in the middle of a byte leaves the registers unchanged.
- R7: Register 0x00 resets to 0x00 and reads back as written. Its bits 7..2 drive motorVset, bit 1 drives motorIn2 and bit 0 drives motorIn1.
- R8: Register 0x01 reads {3'b000, faultStat[4:0]}, in which bit 4 is the extended current limit flag, bit 3 is over-temperature, bit 2 is undervoltage, bit 1 is overcurrent and bit 0 is any fault. Writes do not change the value read.
- R9: Writing a byte with bit 7 set to register 0x01 raises faultClear for exactly one clock. Writing a byte with bit 7 clear raises no pulse.
- R10: A read returns the register selected by the last register-selection byte, MSB first. While the master acknowledges, the same register is sent again. A master not-acknowledge ends the read.
- R11: Any selection other than 0x00 and 0x01 reads as 0x00, and writes to it are ignored.
- R12: The block only pulls SDA low and never drives it high. The pull changes only while SCL is low, and it is released on START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| sdaPullLow | output | 1 | 1 = pull SDA low (open drain) |
| addrSel1 | input | 2 | Upper address pin, three-level code |
| addrSel0 | input | 2 | Lower address pin, three-level code |
| faultStat | input | 5 | Fault status bits shown in register 0x01 |
| motorVset | output | 6 | Drive voltage code |
| motorIn2 | output | 1 | Bridge control bit 2 |
| motorIn1 | output | 1 | Bridge control bit 1 |
| faultClear | output | 1 | One-cycle fault clear pulse |

## Verification
The assertions check four properties on every cycle:
- the clear pulse lasts a single cycle;
- the control register holds whenever no write strobe is present;
- the captured address never moves after its capture;
- SDA is released after a STOP, and the pull changes only during SCL low or at a START or STOP.

The bench scenarios cover what a per-cycle property cannot see:
- whether a given address byte is acknowledged at all;
- the register-selection order;
- commit only after the acknowledge clock, shown by a STOP mid-byte;
- repeated reads of one register;
- reads of unused selections;
- the pin-to-address mapping under pins that change after reset.

// File: rtl/mci2cPkg.sv
package mci2cPkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WR, ST_WR_ACK, ST_RD, ST_RD_ACK
  } busState_t;

  typedef struct packed {
    logic sampleBit;
    logic loadPtr;
    logic writeReg;
    logic loadTx;
    logic shiftTx;
  } strobes_t;

  // three-level pin code: 00 low -> 0, 01 high -> 2, open -> 1
  function automatic logic [1:0] pinWeight(input logic [1:0] code);
    case (code)
      2'b00:   return 2'd0;
      2'b01:   return 2'd2;
      default: return 2'd1;
    endcase
  endfunction
endpackage

// File: rtl/mci2cLineSync.sv
module mci2cLineSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic lineIn,
  output logic level,
  output logic levelPrev
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES < 2) begin : g_bad
      initial $error("mci2cLineSync needs at least two stages");
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain     <= '1;
      levelPrev <= 1'b1;
    end else begin
      chain     <= {chain[STAGES-2:0], lineIn};
      levelPrev <= chain[STAGES-1];
    end
  end

  assign level = chain[STAGES-1];
endmodule

// File: rtl/mci2cCtrl.sv
module mci2cCtrl
  import mci2cPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     sclS,
  input  logic     sclPrev,
  input  logic     sdaS,
  input  logic     sdaPrev,
  input  logic     addrMatch,
  input  logic     rnwBit,
  input  logic     selMsb,
  input  logic     txNext,
  output strobes_t strobe,
  output logic     sdaPullLow
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  busState_t        state, stateNx;
  logic [CNT_W-1:0] bitCnt, cntNx;
  logic             pullNx, isRead, readNx, firstByte, firstNx, masterAck, mAckNx;
  logic             startDet, stopDet, sclRise, sclFall;

  assign startDet = sclS && sclPrev && sdaPrev && !sdaS;
  assign stopDet  = sclS && sclPrev && !sdaPrev && sdaS;
  assign sclRise  = sclS && !sclPrev;
  assign sclFall  = !sclS && sclPrev;

  always_comb begin
    stateNx = state;
    cntNx   = bitCnt;
    pullNx  = sdaPullLow;
    readNx  = isRead;
    firstNx = firstByte;
    mAckNx  = masterAck;
    strobe  = '0;
    if (stopDet) begin
      stateNx = ST_IDLE;
      pullNx  = 1'b0;
    end else if (startDet) begin
      stateNx = ST_ADDR;
      cntNx   = '0;
      pullNx  = 1'b0;
    end else begin
      case (state)
        ST_ADDR: begin
          if (sclRise && bitCnt < FULL) begin
            strobe.sampleBit = 1'b1;
            cntNx = bitCnt + 1'b1;
          end else if (sclFall && bitCnt == FULL) begin
            if (addrMatch) begin
              pullNx  = 1'b1;
              readNx  = rnwBit;
              stateNx = ST_ADDR_ACK;
            end else begin
              stateNx = ST_IDLE;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (sclFall) begin
            if (isRead) begin
              strobe.loadTx = 1'b1;
              pullNx  = !selMsb;
              cntNx   = CNT_W'(1);
              stateNx = ST_RD;
            end else begin
              pullNx  = 1'b0;
              cntNx   = '0;
              firstNx = 1'b1;
              stateNx = ST_WR;
            end
          end
        end
        ST_WR: begin
          if (sclRise && bitCnt < FULL) begin
            strobe.sampleBit = 1'b1;
            cntNx = bitCnt + 1'b1;
          end else if (sclFall && bitCnt == FULL) begin
            pullNx  = 1'b1;
            stateNx = ST_WR_ACK;
          end
        end
        ST_WR_ACK: begin
          if (sclFall) begin
            pullNx = 1'b0;
            if (firstByte) strobe.loadPtr = 1'b1;
            else           strobe.writeReg = 1'b1;
            firstNx = 1'b0;
            cntNx   = '0;
            stateNx = ST_WR;
          end
        end
        ST_RD: begin
          if (sclFall) begin
            if (bitCnt == FULL) begin
              pullNx  = 1'b0;
              stateNx = ST_RD_ACK;
            end else begin
              strobe.shiftTx = 1'b1;
              pullNx = !txNext;
              cntNx  = bitCnt + 1'b1;
            end
          end
        end
        ST_RD_ACK: begin
          if (sclRise) mAckNx = !sdaS;
          else if (sclFall) begin
            if (masterAck) begin
              strobe.loadTx = 1'b1;
              pullNx  = !selMsb;
              cntNx   = CNT_W'(1);
              stateNx = ST_RD;
            end else begin
              pullNx  = 1'b0;
              stateNx = ST_IDLE;
            end
          end
        end
        default: stateNx = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      bitCnt     <= '0;
      sdaPullLow <= 1'b0;
      isRead     <= 1'b0;
      firstByte  <= 1'b0;
      masterAck  <= 1'b0;
    end else begin
      state      <= stateNx;
      bitCnt     <= cntNx;
      sdaPullLow <= pullNx;
      isRead     <= readNx;
      firstByte  <= firstNx;
      masterAck  <= mAckNx;
    end
  end

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    stopDet |=> !sdaPullLow); // R12
  AST_PULL_ON_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(sdaPullLow) && !$past(stopDet) && !$past(startDet)) |-> !$past(sclS)); // R12
endmodule

// File: rtl/mci2cDatapath.sv
module mci2cDatapath
  import mci2cPkg::*;
#(
  parameter logic [6:0] ADDR_BASE = 7'h60,
  parameter logic [7:0] CTRL_SUB  = 8'h00,
  parameter logic [7:0] FAULT_SUB = 8'h01,
  parameter int         CLEAR_BIT = 7,
  parameter int         STATUS_W  = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sdaS,
  input  strobes_t            strobe,
  input  logic [1:0]          addrSel1,
  input  logic [1:0]          addrSel0,
  input  logic [STATUS_W-1:0] faultStat,
  output logic                addrMatch,
  output logic                rnwBit,
  output logic                selMsb,
  output logic                txNext,
  output logic [BYTE_W-1:0]   ctrlReg,
  output logic                faultClear
);
  localparam int PAD_W = BYTE_W - STATUS_W;

  logic [BYTE_W-1:0] rxByte, regPtr, selData;
  logic [BYTE_W-2:0] txByte;
  logic [6:0]        devAddr, pinAddr;
  logic              addrLatched;
  logic [1:0]        w1, w0;

  assign w1 = pinWeight(addrSel1);
  assign w0 = pinWeight(addrSel0);
  assign pinAddr = ADDR_BASE + {5'd0, w1} + {5'd0, w1} + {5'd0, w1} + {5'd0, w0};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      devAddr     <= ADDR_BASE;
      addrLatched <= 1'b0;
    end else if (!addrLatched) begin
      devAddr     <= pinAddr;
      addrLatched <= 1'b1;
    end
  end

  always_comb begin
    if (regPtr == CTRL_SUB)       selData = ctrlReg;
    else if (regPtr == FAULT_SUB) selData = {{PAD_W{1'b0}}, faultStat};
    else                          selData = '0;
  end

  assign addrMatch = addrLatched && (rxByte[7:1] == devAddr) && (rxByte[7:1] != 7'd0);
  assign rnwBit    = rxByte[0];
  assign selMsb    = selData[BYTE_W-1];
  assign txNext    = txByte[BYTE_W-2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxByte     <= '0;
      regPtr     <= '0;
      txByte     <= '0;
      ctrlReg    <= '0;
      faultClear <= 1'b0;
    end else begin
      faultClear <= 1'b0;
      if (strobe.sampleBit) rxByte <= {rxByte[BYTE_W-2:0], sdaS};
      if (strobe.loadPtr)   regPtr <= rxByte;
      if (strobe.loadTx)       txByte <= selData[BYTE_W-2:0];
      else if (strobe.shiftTx) txByte <= {txByte[BYTE_W-3:0], 1'b0};
      if (strobe.writeReg) begin
        if (regPtr == CTRL_SUB) ctrlReg <= rxByte;
        if (regPtr == FAULT_SUB && rxByte[CLEAR_BIT]) faultClear <= 1'b1;
      end
    end
  end

  AST_CLEAR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    faultClear |=> !faultClear); // R9
  AST_CTRL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.writeReg |=> $stable(ctrlReg)); // R6
  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    addrLatched |=> $stable(devAddr)); // R3
endmodule

// File: rtl/mci2cSlave.sv
module mci2cSlave
  import mci2cPkg::*;
#(
  parameter logic [6:0] ADDR_BASE   = 7'h60,
  parameter int         SYNC_STAGES = 2,
  parameter int         STATUS_W    = 5,
  parameter int         VSET_W      = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclIn,
  input  logic                sdaIn,
  output logic                sdaPullLow,
  input  logic [1:0]          addrSel1,
  input  logic [1:0]          addrSel0,
  input  logic [STATUS_W-1:0] faultStat,
  output logic [VSET_W-1:0]   motorVset,
  output logic                motorIn2,
  output logic                motorIn1,
  output logic                faultClear
);
  logic sclS, sclPrev, sdaS, sdaPrev;
  logic addrMatch, rnwBit, selMsb, txNext;
  logic [BYTE_W-1:0] ctrlReg;
  strobes_t strobe;

  mci2cLineSync #(.STAGES(SYNC_STAGES)) uSclSync (
    .clk(clk), .rstN(rstN), .lineIn(sclIn), .level(sclS), .levelPrev(sclPrev));
  mci2cLineSync #(.STAGES(SYNC_STAGES)) uSdaSync (
    .clk(clk), .rstN(rstN), .lineIn(sdaIn), .level(sdaS), .levelPrev(sdaPrev));

  mci2cCtrl uCtrl (
    .clk(clk), .rstN(rstN), .sclS(sclS), .sclPrev(sclPrev), .sdaS(sdaS),
    .sdaPrev(sdaPrev), .addrMatch(addrMatch), .rnwBit(rnwBit), .selMsb(selMsb),
    .txNext(txNext), .strobe(strobe), .sdaPullLow(sdaPullLow));

  mci2cDatapath #(.ADDR_BASE(ADDR_BASE), .STATUS_W(STATUS_W)) uData (
    .clk(clk), .rstN(rstN), .sdaS(sdaS), .strobe(strobe), .addrSel1(addrSel1),
    .addrSel0(addrSel0), .faultStat(faultStat), .addrMatch(addrMatch),
    .rnwBit(rnwBit), .selMsb(selMsb), .txNext(txNext), .ctrlReg(ctrlReg),
    .faultClear(faultClear));

  assign motorVset = ctrlReg[BYTE_W-1 -: VSET_W];
  assign motorIn2  = ctrlReg[1];
  assign motorIn1  = ctrlReg[0];
endmodule

// File: tb/tb_mci2cSlave.sv
module tb_mci2cSlave;
  localparam int HALF = 10;
  localparam int WD   = 150000;

  logic clk = 0, rstN = 0;
  logic sclM = 1, sdaM = 1;
  logic sdaPullLow, motorIn2, motorIn1, faultClear;
  logic [1:0] addrSel1 = 2'b10, addrSel0 = 2'b01;  // open, high -> 0x65
  logic [4:0] faultStat = 5'b10101;
  logic [5:0] motorVset;
  wire  sdaLine = sdaM & ~sdaPullLow;

  always #10 clk = ~clk;  // 50 MHz

  mci2cSlave dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .sdaPullLow(sdaPullLow),
    .addrSel1(addrSel1), .addrSel0(addrSel0), .faultStat(faultStat),
    .motorVset(motorVset), .motorIn2(motorIn2), .motorIn1(motorIn1),
    .faultClear(faultClear));

  typedef struct { string req; int val; } item_t;
  item_t expQ[$];
  int    actQ[$];
  int    errors = 0, checks = 0;
  bit    done = 0;
  int    clrPulses = 0, clrRun = 0, clrMaxRun = 0;

  task automatic expectVal(string req, int v);
    item_t it; it.req = req; it.val = v; expQ.push_back(it);
  endtask
  task automatic observe(int v);
    actQ.push_back(v);
  endtask

  // monitor: pops and compares
  initial forever begin
    @(negedge clk);
    while (actQ.size() > 0) begin
      int a; item_t e;
      a = actQ.pop_front();
      checks++;
      if (expQ.size() == 0) begin
        errors++; $display("FAIL scoreboard: unexpected item actual=%0h expected=none", a);
      end else begin
        e = expQ.pop_front();
        if (a != e.val) begin
          errors++; $display("FAIL %s: actual=%0h expected=%0h", e.req, a, e.val);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (faultClear) begin
      if (clrRun == 0) clrPulses++;
      clrRun++;
      if (clrRun > clrMaxRun) clrMaxRun = clrRun;
    end else clrRun = 0;
  end

  task automatic waitH(); repeat (HALF) @(negedge clk); endtask
  task automatic busStart(); sdaM = 1; waitH(); sclM = 1; waitH(); sdaM = 0; waitH(); sclM = 0; repeat (2) @(negedge clk); endtask
  task automatic busStop(); sdaM = 0; waitH(); sclM = 1; waitH(); sdaM = 1; waitH(); endtask
  task automatic sendBit(input bit b);
    sdaM = b; waitH(); sclM = 1; waitH(); sclM = 0; repeat (2) @(negedge clk);
  endtask
  task automatic getBit(output bit b);
    sdaM = 1; waitH(); sclM = 1; repeat (HALF/2) @(negedge clk);
    b = sdaLine; repeat (HALF - HALF/2) @(negedge clk); sclM = 0; repeat (2) @(negedge clk);
  endtask
  task automatic writeByte(input logic [7:0] v, output bit ack);
    bit b;
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    getBit(b); ack = !b;
  endtask
  task automatic readByte(output logic [7:0] v, input bit giveAck);
    bit b;
    for (int i = 0; i < 8; i++) begin getBit(b); v = {v[6:0], b}; end
    sendBit(!giveAck);
  endtask

  localparam logic [7:0] AW = 8'hCA, AR = 8'hCB;

  task automatic regWrite(input logic [7:0] sub, input logic [7:0] d, output bit allAck);
    bit a0, a1, a2;
    busStart(); writeByte(AW, a0); writeByte(sub, a1); writeByte(d, a2); busStop();
    allAck = a0 & a1 & a2;
  endtask
  task automatic regRead(input logic [7:0] sub, output logic [7:0] d);
    bit a;
    busStart(); writeByte(AW, a); writeByte(sub, a);
    busStart(); writeByte(AR, a); readByte(d, 1'b0); busStop();
  endtask

  initial begin
    logic [7:0] d, d2;
    bit ack;
    repeat (5) @(negedge clk);
    rstN = 1;
    repeat (5) @(negedge clk);
    // R3: move pins after capture
    addrSel1 = 2'b00; addrSel0 = 2'b00;
    repeat (3) @(negedge clk);

    expectVal("R7 reset vset", 0); observe(motorVset);
    expectVal("R7 reset in bits", 0); observe({motorIn2, motorIn1});
    expectVal("R12 reset released", 0); observe(sdaPullLow);

    // R1: clock pulses without START
    for (int i = 7; i >= 0; i--) sendBit(AW[i]);
    getBit(ack);
    expectVal("R1 no ack without START", 1); observe(ack);

    // R2/R4/R5/R7 write control
    regWrite(8'h00, 8'hA5, ack);
    expectVal("R4 R5 acks on write", 1); observe(ack);
    expectVal("R7 vset field", 6'h29); observe(motorVset);
    expectVal("R7 in2/in1", 2'b01); observe({motorIn2, motorIn1});
    expectVal("R12 released after STOP", 0); observe(sdaPullLow);
    regRead(8'h00, d);
    expectVal("R10 read back control", 8'hA5); observe(d);

    // R3/R4: address from current pins (0x60) must not answer
    busStart(); writeByte(8'hC0, ack); busStop();
    expectVal("R3 late pin change ignored", 0); observe(ack);
    busStart(); writeByte(8'h00, ack); busStop();
    expectVal("R4 general call ignored", 0); observe(ack);
    busStart(); writeByte(8'hCC, ack); writeByte(8'h00, ack); writeByte(8'h00, ack); busStop();
    expectVal("R4 wrong address write ignored", 8'hA5); observe({motorVset, motorIn2, motorIn1});

    // R8 fault status read
    regRead(8'h01, d);
    expectVal("R8 status read", 8'h15); observe(d);
    regWrite(8'h01, 8'h7F, ack);
    expectVal("R9 no clear pulse without bit7", 0); observe(clrPulses);
    regRead(8'h01, d);
    expectVal("R8 status unchanged by write", 8'h15); observe(d);
    regWrite(8'h01, 8'h80, ack);
    expectVal("R9 one clear pulse", 1); observe(clrPulses);
    expectVal("R9 pulse width", 1); observe(clrMaxRun);

    // R5 multi-byte write to the same register
    busStart(); writeByte(AW, ack); writeByte(8'h00, ack); writeByte(8'h11, ack); writeByte(8'h22, ack); busStop();
    expectVal("R5 last byte in same register", 1); observe(ack);
    expectVal("R5 control holds last byte", 8'h22); observe({motorVset, motorIn2, motorIn1});

    // R10 repeated read with master ack, then nack
    busStart(); writeByte(AR, ack); readByte(d, 1'b1); readByte(d2, 1'b0); busStop();
    expectVal("R10 first read byte", 8'h22); observe(d);
    expectVal("R10 second read byte same reg", 8'h22); observe(d2);

    // R6 stop mid-byte
    busStart(); writeByte(AW, ack); writeByte(8'h00, ack);
    for (int i = 0; i < 4; i++) sendBit(1'b1);
    busStop();
    expectVal("R6 partial byte discarded", 8'h22); observe({motorVset, motorIn2, motorIn1});

    // R11 unused selection
    regWrite(8'h05, 8'hFF, ack);
    regRead(8'h05, d);
    expectVal("R11 unused reads zero", 0); observe(d);
    expectVal("R11 control untouched", 8'h22); observe({motorVset, motorIn2, motorIn1});
    expectVal("R12 released at end", 0); observe(sdaPullLow);

    repeat (20) @(negedge clk);
    if (expQ.size() != 0) begin
      errors++; $display("FAIL scoreboard: %0d expected items unmatched actual=0 expected=%0d", expQ.size(), expQ.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WD) @(negedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule